// File: doc/BRIEF.md
# Burst Serial Transmitter

This block sends one outgoing radio burst as a serial bit stream, one bit per clock. A slot-sync pulse arms it and starts a slot counter. The block then reads the sync field, the A-field and the B-field byte by byte from a shared data memory, starting at three base addresses captured at the slot-sync pulse. Each field has its own address register, which advances by one for every byte read. The B-field can be scrambled with a keystream. A 4-bit check code is computed over the transmitted B-field bits. The block sends that code once as the X-field and then once more as the Z-field.

The first bit can be moved earlier than the nominal slot position by 0 to 15 bit periods, which makes up for delay in the radio path. A polarity control inverts every bit the block drives, idle level included, for modulators that expect negative modulation. Outside a burst the output rests at the idle level. A one-cycle completion pulse follows the last Z bit.

Top module: `burst_serial_tx`

## Requirements
- R1: After reset, `burst_done` and `mem_rd` are 0 and `tx_data` equals `invert_mode`.
- R2: The slot counter is 0 in the cycle after the accepted `slot_sync` edge and counts up by one per cycle. Bit 0 of the burst appears on `tx_data` in the cycle where the counter equals NOM_START minus the `tx_advance` value latched at that edge (NOM_START defaults to 24). Before that cycle `tx_data` stays at the idle level.
- R3: The burst is 424 bits long and sent in this order: sync field (32 bits, bits 0..31), A-field (64 bits, bits 32..95), B-field (320 bits, bits 96..415), X-field (bits 416..419), Z-field (bits 420..423). Byte k of a field is read from address base+k (modulo 256), and each byte is sent most significant bit first.
- R4: Memory reads have a one-cycle latency. `mem_rd` is high for exactly one cycle per byte, which is 52 times per burst, and the data is taken from `mem_rdata` in the following cycle.
- R5: When `scramble_en` is 1 at the slot-sync edge, each B-field bit is XORed with bit 6 of a 7-bit shift register. The register is set to all ones at burst start and steps once per B-field bit: it shifts left and takes bit6 XOR bit3 into bit 0. When `scramble_en` is 0, the B-field is sent unchanged.
- R6: The X-field is a 4-bit CRC with polynomial x^4+x+1 and initial value 4'hF, fed with the B-field bits as transmitted. For each bit d: fb = crc[3]^d; crc = {crc[2:0],0} XOR (fb ? 4'b0011 : 0). The field is sent crc[3] first.
- R7: The Z-field repeats the four X-field bits in the same order.
- R8: `invert_mode` XORs every value driven on `tx_data`, both burst bits and the idle level (idle level 0 before inversion), and takes effect at once.
- R9: `burst_done` is 1 for exactly one cycle, the cycle after the last Z bit. In that cycle `tx_data` is back at the idle level.
- R10: `tx_advance`, `scramble_en` and the three base addresses are latched at the accepted `slot_sync` edge. A `slot_sync` pulse or a change on those inputs while a burst is armed has no effect on the burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one bit period per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_sync | input | 1 | Slot start pulse; arms a burst when idle |
| tx_advance | input | 4 | Bit periods by which the first bit is moved earlier |
| invert_mode | input | 1 | Output polarity inversion |
| scramble_en | input | 1 | Enable B-field scrambling |
| s_base | input | 8 | Start address of the sync field |
| a_base | input | 8 | Start address of the A-field |
| b_base | input | 8 | Start address of the B-field |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | 8 | Memory read address |
| mem_rdata | input | 8 | Read data, valid one cycle after `mem_rd` |
| tx_data | output | 1 | Serial burst output |
| burst_done | output | 1 | One-cycle pulse after the last Z bit |

## Verification
The assertions assume a memory that returns the data one cycle after each strobe. They also assume that `slot_sync` is only acted on while idle and that reset sets the sequencer and address registers to a known state. The bench's memory model is a registered array that answers exactly one cycle after `mem_rd`, so it meets the latency the assertions rely on. Slot-sync pulses and input changes during a burst are applied only in a dedicated run, which checks that they are ignored. Every advance value is swept with all four combinations of polarity and scrambling, with fresh memory contents and base addresses in each run. Every bit of every burst is compared against a value computed in the bench.

// File: rtl/bst_pkg.sv
package bst_pkg;
   localparam int BYTE_W = 8;
   typedef enum logic [1:0] {SEL_S = 2'd0, SEL_A = 2'd1, SEL_B = 2'd2} fetch_sel_e;
endpackage

// File: rtl/bst_slot_timer.sv
module bst_slot_timer #(
   parameter int ADV_W     = 4,
   parameter int NOM_START = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             slot_sync,
   input  logic [ADV_W-1:0] advance,
   input  logic             burst_end,
   output logic             armed,
   output logic             take,
   output logic             pre_rd,
   output logic             launch
);
   localparam int CNT_W = $clog2(NOM_START + 1);
   localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(NOM_START);

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] start_pt;
   logic [ADV_W-1:0] adv_q;

   assign take     = slot_sync & ~armed;
   assign start_pt = CNT_MAX - CNT_W'(adv_q);
   assign pre_rd   = armed && (cnt == start_pt - CNT_W'(2));
   assign launch   = armed && (cnt == start_pt - CNT_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed <= 1'b0;
         cnt   <= '0;
         adv_q <= '0;
      end else if (take) begin
         armed <= 1'b1;
         cnt   <= '0;
         adv_q <= advance;
      end else begin
         if (burst_end) armed <= 1'b0;
         if (armed && cnt != CNT_MAX) cnt <= cnt + CNT_W'(1);
      end
   end

   // R10: advance cannot move while a burst is armed
   a_r10_adv_hold: assert property (@(posedge clk) disable iff (!rst_n)
      armed |=> $stable(adv_q));
endmodule

// File: rtl/bst_fetch.sv
module bst_fetch import bst_pkg::*; #(
   parameter int S_BITS = 32,
   parameter int A_BITS = 64,
   parameter int B_BITS = 320,
   parameter int ADDR_W = 8,
   parameter int POS_W  = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take,
   input  logic [ADDR_W-1:0] s_base,
   input  logic [ADDR_W-1:0] a_base,
   input  logic [ADDR_W-1:0] b_base,
   input  logic              pre_rd,
   input  logic              launch,
   input  logic              active,
   input  logic [POS_W-1:0]  pos,
   input  logic [BYTE_W-1:0] mem_rdata,
   output logic              mem_rd,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              raw_bit
);
   localparam int MEM_BITS = S_BITS + A_BITS + B_BITS;
   localparam logic [POS_W-1:0] A_START = POS_W'(S_BITS);
   localparam logic [POS_W-1:0] B_START = POS_W'(S_BITS + A_BITS);
   localparam logic [POS_W-1:0] M_END   = POS_W'(MEM_BITS);

   logic [ADDR_W-1:0] s_ptr, a_ptr, b_ptr;
   logic [BYTE_W-1:0] shift_q;
   logic [POS_W-1:0]  ahead;
   logic              load_now;
   fetch_sel_e        sel;

   assign ahead = pos + POS_W'(2);

   always_comb begin
      if (pre_rd || ahead < A_START) sel = SEL_S;
      else if (ahead < B_START)      sel = SEL_A;
      else                           sel = SEL_B;
   end

   assign mem_rd   = pre_rd | (active && pos[2:0] == 3'd6 && ahead < M_END);
   assign load_now = launch | (active && pos[2:0] == 3'd7 && (pos + POS_W'(1)) < M_END);

   always_comb begin
      unique case (sel)
         SEL_S:   mem_addr = s_ptr;
         SEL_A:   mem_addr = a_ptr;
         default: mem_addr = b_ptr;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s_ptr <= '0;
         a_ptr <= '0;
         b_ptr <= '0;
      end else if (take) begin
         s_ptr <= s_base;
         a_ptr <= a_base;
         b_ptr <= b_base;
      end else if (mem_rd) begin
         unique case (sel)
            SEL_S:   s_ptr <= s_ptr + ADDR_W'(1);
            SEL_A:   a_ptr <= a_ptr + ADDR_W'(1);
            default: b_ptr <= b_ptr + ADDR_W'(1);
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)        shift_q <= '0;
      else if (load_now) shift_q <= mem_rdata;
      else if (active)   shift_q <= {shift_q[BYTE_W-2:0], 1'b0};
   end

   assign raw_bit = shift_q[BYTE_W-1];

   // R4: every byte loaded into the shifter was requested one cycle earlier
   a_r4_fetch_ahead: assert property (@(posedge clk) disable iff (!rst_n)
      load_now |-> $past(mem_rd));
endmodule

// File: rtl/bst_coder.sv
module bst_coder #(
   parameter int              S_BITS   = 32,
   parameter int              A_BITS   = 64,
   parameter int              B_BITS   = 320,
   parameter int              POS_W    = 9,
   parameter bit              USE_SCR  = 1'b1,
   parameter int              SCR_W    = 7,
   parameter logic [SCR_W-1:0] SCR_TAPS = 7'h48,
   parameter int              CRC_W    = 4,
   parameter logic [CRC_W-1:0] CRC_POLY = 4'b0011,
   parameter logic [CRC_W-1:0] CRC_INIT = 4'hF
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             launch,
   input  logic             active,
   input  logic [POS_W-1:0] pos,
   input  logic             raw_bit,
   input  logic             scr_on,
   output logic             code_bit
);
   localparam logic [POS_W-1:0] B_START = POS_W'(S_BITS + A_BITS);
   localparam logic [POS_W-1:0] M_END   = POS_W'(S_BITS + A_BITS + B_BITS);

   logic             in_b, in_chk, ks, d, fb;
   logic [CRC_W-1:0] crc;

   assign in_b   = active && pos >= B_START && pos < M_END;
   assign in_chk = active && pos >= M_END;

   generate
      if (USE_SCR) begin : g_scr
         logic [SCR_W-1:0] lfsr;
         always_ff @(posedge clk) begin
            if (!rst_n || launch) lfsr <= '1;
            else if (in_b)        lfsr <= {lfsr[SCR_W-2:0], ^(lfsr & SCR_TAPS)};
         end
         assign ks = scr_on & lfsr[SCR_W-1];
      end else begin : g_plain
         assign ks = 1'b0 & scr_on;
      end
   endgenerate

   assign d  = raw_bit ^ ks;
   assign fb = crc[CRC_W-1] ^ d;

   always_ff @(posedge clk) begin
      if (!rst_n || launch) crc <= CRC_INIT;
      else if (in_b)        crc <= {crc[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
      else if (in_chk)      crc <= {crc[CRC_W-2:0], crc[CRC_W-1]};
   end

   assign code_bit = in_chk ? crc[CRC_W-1] : (in_b ? d : raw_bit);

   // R6: the check register only moves while a burst runs or starts
   a_r6_crc_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!active && !launch) |=> $stable(crc));
endmodule

// File: rtl/burst_serial_tx.sv
module burst_serial_tx import bst_pkg::*; #(
   parameter int S_BITS    = 32,
   parameter int A_BITS    = 64,
   parameter int B_BITS    = 320,
   parameter int CRC_W     = 4,
   parameter int ADDR_W    = 8,
   parameter int ADV_W     = 4,
   parameter int NOM_START = 24,
   parameter bit USE_SCR   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              slot_sync,
   input  logic [ADV_W-1:0]  tx_advance,
   input  logic              invert_mode,
   input  logic              scramble_en,
   input  logic [ADDR_W-1:0] s_base,
   input  logic [ADDR_W-1:0] a_base,
   input  logic [ADDR_W-1:0] b_base,
   output logic              mem_rd,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic [BYTE_W-1:0] mem_rdata,
   output logic              tx_data,
   output logic              burst_done
);
   localparam int TOTAL = S_BITS + A_BITS + B_BITS + 2 * CRC_W;
   localparam int POS_W = $clog2(TOTAL + 1);
   localparam logic [POS_W-1:0] LAST = POS_W'(TOTAL - 1);

   generate
      if ((S_BITS % BYTE_W) != 0 || (A_BITS % BYTE_W) != 0 || (B_BITS % BYTE_W) != 0) begin : g_chk_bytes
         $error("field lengths must be whole bytes");
      end
      if (NOM_START < (1 << ADV_W) + 1) begin : g_chk_start
         $error("NOM_START too small for the largest advance");
      end
      if (CRC_W < 2) begin : g_chk_crc
         $error("check code needs at least two bits");
      end
   endgenerate

   logic             armed, take, pre_rd, launch, burst_end;
   logic             active, scr_q, raw_bit, code_bit;
   logic [POS_W-1:0] pos;

   assign burst_end = active && pos == LAST;

   bst_slot_timer #(.ADV_W(ADV_W), .NOM_START(NOM_START)) u_timer (
      .clk(clk), .rst_n(rst_n), .slot_sync(slot_sync), .advance(tx_advance),
      .burst_end(burst_end), .armed(armed), .take(take), .pre_rd(pre_rd),
      .launch(launch));

   bst_fetch #(.S_BITS(S_BITS), .A_BITS(A_BITS), .B_BITS(B_BITS),
               .ADDR_W(ADDR_W), .POS_W(POS_W)) u_fetch (
      .clk(clk), .rst_n(rst_n), .take(take), .s_base(s_base), .a_base(a_base),
      .b_base(b_base), .pre_rd(pre_rd), .launch(launch), .active(active),
      .pos(pos), .mem_rdata(mem_rdata), .mem_rd(mem_rd), .mem_addr(mem_addr),
      .raw_bit(raw_bit));

   bst_coder #(.S_BITS(S_BITS), .A_BITS(A_BITS), .B_BITS(B_BITS), .POS_W(POS_W),
               .USE_SCR(USE_SCR), .CRC_W(CRC_W)) u_coder (
      .clk(clk), .rst_n(rst_n), .launch(launch), .active(active), .pos(pos),
      .raw_bit(raw_bit), .scr_on(scr_q), .code_bit(code_bit));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active     <= 1'b0;
         pos        <= '0;
         burst_done <= 1'b0;
         scr_q      <= 1'b0;
      end else begin
         burst_done <= 1'b0;
         if (take) scr_q <= scramble_en;
         if (launch) begin
            active <= 1'b1;
            pos    <= '0;
         end else if (active) begin
            if (pos == LAST) begin
               active     <= 1'b0;
               burst_done <= 1'b1;
            end else begin
               pos <= pos + POS_W'(1);
            end
         end
      end
   end

   assign tx_data = invert_mode ^ (active & code_bit);

   // R9: completion is a single-cycle pulse
   a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      burst_done |=> !burst_done);
   // R9: completion follows the end of the burst and the line is idle
   a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      burst_done |-> (!active && tx_data == invert_mode));
   // R3: bit position never leaves the burst length
   a_r3_pos_range: assert property (@(posedge clk) disable iff (!rst_n)
      active |-> pos <= LAST);
   // R4: memory is only read for an armed burst
   a_r4_rd_armed: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd |-> armed);
endmodule

// File: tb/sim_burst_serial_tx.sv
module sim_burst_serial_tx;
   localparam int NOM   = 24;
   localparam int TOTAL = 424;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       slot_sync = 1'b0;
   logic [3:0] tx_advance = '0;
   logic       invert_mode = 1'b0;
   logic       scramble_en = 1'b0;
   logic [7:0] s_base = '0, a_base = '0, b_base = '0;
   logic       mem_rd;
   logic [7:0] mem_addr;
   logic [7:0] mem_rdata = '0;
   logic       tx_data, burst_done;

   logic [7:0] mem [256];
   logic       exp_bits [TOTAL];
   int total = 0;
   int bad = 0;

   always #4 clk = ~clk;

   always @(posedge clk) if (mem_rd) mem_rdata <= mem[mem_addr];

   burst_serial_tx u0 (
      .clk(clk), .rst_n(rst_n), .slot_sync(slot_sync), .tx_advance(tx_advance),
      .invert_mode(invert_mode), .scramble_en(scramble_en), .s_base(s_base),
      .a_base(a_base), .b_base(b_base), .mem_rd(mem_rd), .mem_addr(mem_addr),
      .mem_rdata(mem_rdata), .tx_data(tx_data), .burst_done(burst_done));

   task automatic chk(input bit ok, input string tag, input int act, input int expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, expv, $time);
      end
   endtask

   function automatic string tag_of(input int i, input bit scr);
      if (i < 96)  return "R3";
      if (i < 416) return scr ? "R5" : "R3";
      if (i < 420) return "R6";
      return "R7";
   endfunction

   task automatic build(input int run, input bit scr, input logic [7:0] sb,
                        input logic [7:0] ab, input logic [7:0] bb);
      logic [6:0] l;
      logic [3:0] c;
      for (int k = 0; k < 256; k++) mem[k] = 8'(k * 29 + run * 7 + 3);
      l = 7'h7F;
      c = 4'hF;
      for (int i = 0; i < 416; i++) begin
         int b;
         logic [7:0] ad;
         logic bt, fbk;
         b = i / 8;
         if (b < 4)       ad = sb + 8'(b);
         else if (b < 12) ad = ab + 8'(b - 4);
         else             ad = bb + 8'(b - 12);
         bt = mem[ad][7 - (i % 8)];
         if (i >= 96) begin
            bt  = bt ^ (scr & l[6]);
            l   = {l[5:0], l[6] ^ l[3]};
            fbk = c[3] ^ bt;
            c   = {c[2:0], 1'b0} ^ (fbk ? 4'b0011 : 4'b0000);
         end
         exp_bits[i] = bt;
      end
      for (int j = 0; j < 4; j++) begin
         exp_bits[416 + j] = c[3 - j];
         exp_bits[420 + j] = c[3 - j];
      end
   endtask

   task automatic run_burst(input int run, input logic [3:0] adv, input bit inv,
                            input bit scr, input bit disturb);
      logic [7:0] sb, ab, bb;
      int start, reads;
      sb = 8'(run * 5);
      ab = 8'(run * 5 + 40);
      bb = 8'(run * 11 + 90);
      build(run, scr, sb, ab, bb);
      start = NOM - int'(adv);
      reads = 0;
      @(negedge clk);
      tx_advance = adv; invert_mode = inv; scramble_en = scr;
      s_base = sb; a_base = ab; b_base = bb;
      slot_sync = 1'b1;
      @(posedge clk);
      @(negedge clk);
      slot_sync = 1'b0;
      for (int n = 0; n < start + TOTAL + 3; n++) begin
         if (mem_rd) reads++;
         if (n < start) begin
            // R2: line idle until the advanced start point
            chk(tx_data == inv, disturb ? "R10" : "R2", tx_data, inv);
         end else if (n < start + TOTAL) begin
            chk(tx_data == (inv ^ exp_bits[n - start]),
                disturb ? "R10" : (inv ? "R8" : tag_of(n - start, scr)),
                tx_data, inv ^ exp_bits[n - start]);
         end else begin
            chk(tx_data == inv, "R9", tx_data, inv);
         end
         // R9: single done pulse right after the last Z bit
         chk(burst_done == (n == start + TOTAL), "R9", burst_done, (n == start + TOTAL));
         if (disturb && n == start + 100) begin
            slot_sync = 1'b1;
            tx_advance = ~adv; scramble_en = ~scr;
            s_base = 8'hAA; a_base = 8'h55; b_base = 8'h0F;
         end else begin
            slot_sync = 1'b0;
         end
         @(negedge clk);
      end
      // R4: one read strobe per byte of the memory fields
      chk(reads == 52, "R4", reads, 52);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int run;
      run = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk(tx_data == 1'b0, "R1", tx_data, 0);
      chk(burst_done == 1'b0, "R1", burst_done, 0);
      chk(mem_rd == 1'b0, "R1", mem_rd, 0);
      // R8: idle level follows inversion immediately
      invert_mode = 1'b1;
      #1;
      chk(tx_data == 1'b1, "R8", tx_data, 1);
      invert_mode = 1'b0;
      for (int a = 0; a < 16; a++) begin
         for (int m = 0; m < 4; m++) begin
            run_burst(run, 4'(a), m[0], m[1], 1'b0);
            run++;
         end
      end
      // R10: slot_sync and input changes during a burst are ignored
      run_burst(run, 4'd7, 1'b0, 1'b1, 1'b1);
      run++;
      run_burst(run, 4'd15, 1'b1, 1'b0, 1'b1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule